// File: doc/BRIEF.md
# Signed Divide and Remainder Unit

This block divides two signed two's-complement integers over several cycles. A select input picks which value comes back: the quotient, truncated toward zero, or the remainder, which takes the sign of the dividend. A caller raises `start` for one cycle with both operands, waits for a one-cycle `done` pulse, and then reads `result` and the status flags. These stay unchanged until the next accepted start.

Internally the unit divides the magnitudes of the operands with a restoring radix-2 loop, one quotient bit per cycle. A final cycle then applies the signs. Two operand pairs skip the loop and finish on the start edge.

- A zero divisor produces the largest positive value and raises a halt request for the machine.
- The most negative dividend divided by minus one saturates to the most negative value and raises the overflow flag.

A scalar pipeline can use the unit for its divide and remainder operations. A vector sequencer can also share it, one element at a time.

Top module: `sdiv_unit`

## Requirements
- R1: With `rem_sel` = 0 and a non-special operand pair, `result` is the quotient dividend/divisor truncated toward zero.
- R2: With `rem_sel` = 1 and a non-special operand pair, `result` is the remainder. It has the sign of the dividend, is zero when the division is exact, and satisfies dividend = quotient*divisor + remainder.
- R3: When the divisor is zero, in either mode and for any dividend, `result` is 32'h7FFF_FFFF (all ones below a clear sign bit), `halt_req` is 1 and `ovf` is 0.
- R4: When the dividend is the most negative value (sign bit alone set) and the divisor is all ones (-1), `result` is the most negative value in either mode, `ovf` is 1 and `halt_req` is 0.
- R5: For every operand pair other than those in R3 and R4, `ovf` and `halt_req` are both 0 at completion.
- R6: `unf` is 0 after every completed operation.
- R7: A non-special start puts `busy` high on the following edge. `done` rises on the W+1-th rising edge after the edge that samples `start` (33 edges for W = 32). `done` is never high while `busy` is high.
- R8: The cases in R3 and R4 finish without iterating: the edge that samples `start` also drives `done` high, and `busy` stays low.
- R9: `done` is high for exactly one cycle. `result`, `ovf` and `halt_req` hold their values until the next accepted start.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running operation completes with its own operands and its normal latency.
- R11: While reset is asserted, and just after it is released, `busy`, `done`, `ovf`, `unf` and `halt_req` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an operation when the unit is idle |
| rem_sel | input | 1 | 0 selects the quotient, 1 selects the remainder |
| dividend | input | W | Signed dividend, sampled with `start` |
| divisor | input | W | Signed divisor, sampled with `start` |
| busy | output | 1 | High while the iteration loop or the sign cycle is running |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | W | Quotient or remainder, held until the next start |
| ovf | output | 1 | Most-negative-by-minus-one saturation occurred |
| unf | output | 1 | Underflow flag, cleared by every operation |
| halt_req | output | 1 | Divide by zero: the machine should halt |

## Verification
Most internal faults show up in `result` itself. A wrong shift or restore step in the loop corrupts the low quotient bits or the remainder magnitude. A wrong sign choice flips only the operand pairs whose signs differ. Both errors appear at the single `done` pulse of the affected operation. A fault in the iteration count or the state sequencing moves `done` off its fixed edge, so the bench measures latency exactly on every operation. A fault in the special-case detection shows as a missing flag, a wrong saturated value or a multi-cycle completion, in the cycle right after the start edge.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_special.sv
module sdiv_special #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         div_zero,
  output logic         min_by_neg1,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_q,
  output logic         neg_r
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_comb begin
    div_zero    = (divisor == '0);
    min_by_neg1 = (dividend == MOST_NEG) && (divisor == ALL_ONES);
    mag_a       = dividend[W-1] ? (~dividend + 1'b1) : dividend;
    mag_b       = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
    neg_q       = dividend[W-1] ^ divisor[W-1];
    neg_r       = dividend[W-1];
  end
endmodule

// File: rtl/sdiv_iter.sv
module sdiv_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         last
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, trial;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    last    = run && (cnt_q == CW'(W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      quo_q <= mag_a;
      rem_q <= '0;
      dvs_q <= mag_b;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
      if (!trial[W]) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         rem_sel,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         unf,
  output logic         halt_req
);
  import sdiv_pkg::*;

  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  sdiv_state_e state_q;
  logic div_zero, min_by_neg1, neg_q, neg_r;
  logic [W-1:0] mag_a, mag_b, quo, rem;
  logic last, accept, load, run;
  logic neg_q_q, neg_r_q, rem_sel_q;
  logic [W-1:0] quo_signed, rem_signed;

  sdiv_special #(.W(W)) special_i (
    .dividend    (dividend),
    .divisor     (divisor),
    .div_zero    (div_zero),
    .min_by_neg1 (min_by_neg1),
    .mag_a       (mag_a),
    .mag_b       (mag_b),
    .neg_q       (neg_q),
    .neg_r       (neg_r)
  );

  always_comb begin
    accept = start && (state_q == ST_IDLE);
    load   = accept && !div_zero && !min_by_neg1;
    run    = (state_q == ST_ITER);
  end

  sdiv_iter #(.W(W)) iter_i (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .run   (run),
    .mag_a (mag_a),
    .mag_b (mag_b),
    .quo   (quo),
    .rem   (rem),
    .last  (last)
  );

  always_comb begin
    quo_signed = neg_q_q ? (~quo + 1'b1) : quo;
    rem_signed = neg_r_q ? (~rem + 1'b1) : rem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      done      <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
      halt_req  <= 1'b0;
      neg_q_q   <= 1'b0;
      neg_r_q   <= 1'b0;
      rem_sel_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (div_zero) begin
              result   <= MOST_POS;
              halt_req <= 1'b1;
              ovf      <= 1'b0;
              unf      <= 1'b0;
              done     <= 1'b1;
            end else if (min_by_neg1) begin
              result   <= MOST_NEG;
              halt_req <= 1'b0;
              ovf      <= 1'b1;
              unf      <= 1'b0;
              done     <= 1'b1;
            end else begin
              neg_q_q   <= neg_q;
              neg_r_q   <= neg_r;
              rem_sel_q <= rem_sel;
              state_q   <= ST_ITER;
            end
          end
        end
        ST_ITER: begin
          if (last) state_q <= ST_FIX;
        end
        ST_FIX: begin
          result   <= rem_sel_q ? rem_signed : quo_signed;
          ovf      <= 1'b0;
          unf      <= 1'b0;
          halt_req <= 1'b0;
          done     <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/sdiv_unit_chk.sv
module sdiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic         ovf,
  input logic         unf,
  input logic         halt_req
);
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  AST_ZERO_DIV_FAST: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> (done && !busy && halt_req && result == MOST_POS)); // R3
  AST_MIN_NEG1_FAST: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor != '0 && dividend == MOST_NEG && divisor == ALL_ONES)
      |=> (done && !busy && ovf && result == MOST_NEG)); // R4
  AST_NORMAL_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor != '0 && !(dividend == MOST_NEG && divisor == ALL_ONES))
      |=> (busy && !done)); // R7
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(result) && $stable(ovf) && $stable(halt_req))); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> !ovf); // R5
  AST_OVF_VALUE: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (result == MOST_NEG)); // R4
  AST_UNF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done |-> !unf); // R6
endmodule

bind sdiv_unit sdiv_unit_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .dividend (dividend),
  .divisor  (divisor),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .ovf      (ovf),
  .unf      (unf),
  .halt_req (halt_req)
);

// File: tb/sdiv_unit_tb_top.sv
module sdiv_unit_tb_top;
  localparam int W = 32;
  localparam int NV = 13;
  localparam int LAT = W + 1;

  localparam int TA[NV] = '{100, -100, 100, -100, 7, 0, 32'sh7FFFFFFF, 32'sh80000000,
                            32'sh80000000, 32'sh80000000, 32'sh80000000, -1, 123456789};
  localparam int TB[NV] = '{7, 7, -7, -7, 100, 5, 1, 1, 2, 3, 32'sh7FFFFFFF,
                            32'sh80000000, -1000};
  localparam int TQ[NV] = '{14, -14, -14, 14, 0, 0, 32'sh7FFFFFFF, 32'sh80000000,
                            32'shC0000000, 32'shD5555556, -1, 0, -123456};
  localparam int TR[NV] = '{2, -2, 2, -2, 7, 0, 0, 0, 0, -2, -1, -1, 789};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rem_sel = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic busy, done, ovf, unf, halt_req;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  int lat;
  logic [W-1:0] held;

  always #5 clk = ~clk;

  sdiv_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .rem_sel(rem_sel),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .result(result), .ovf(ovf), .unf(unf), .halt_req(halt_req)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input int a, input int b, input logic m);
    @(negedge clk);
    dividend = a;
    divisor  = b;
    rem_sel  = m;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy", {31'd0, busy}, 0);
    chk("R11 done", {31'd0, done}, 0);
    chk("R11 result", result, 0);
    chk("R11 flags", {29'd0, ovf, unf, halt_req}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 after release", {28'd0, busy, done, ovf, halt_req}, 0);

    for (int i = 0; i < NV; i++) begin
      for (int m = 0; m < 2; m++) begin
        launch(TA[i], TB[i], m[0]);
        chk("R7 busy after start", {31'd0, busy}, 1);
        wait_done();
        chk("R7 latency", lat, LAT);
        if (m == 0) chk("R1 quotient", result, TQ[i]);
        else        chk("R2 remainder", result, TR[i]);
        chk("R5 ovf/halt clear", {30'd0, ovf, halt_req}, 0);
        chk("R6 unf", {31'd0, unf}, 0);
      end
    end

    // divide by zero, both modes, several dividends
    for (int m = 0; m < 2; m++) begin
      launch(32'sh80000000, 0, m[0]);
      chk("R8 zero-div done at once", {30'd0, done, busy}, 2'b10);
      chk("R3 zero-div result", result, 32'h7FFFFFFF);
      chk("R3 zero-div flags", {29'd0, halt_req, ovf, unf}, 3'b100);
      launch(-5, 0, m[0]);
      chk("R3 zero-div neg", result, 32'h7FFFFFFF);
      chk("R3 zero-div halt", {31'd0, halt_req}, 1);
    end

    // most negative by minus one, both modes
    for (int m = 0; m < 2; m++) begin
      launch(32'sh80000000, -1, m[0]);
      chk("R8 sat done at once", {30'd0, done, busy}, 2'b10);
      chk("R4 sat result", result, 32'h80000000);
      chk("R4 sat flags", {29'd0, ovf, halt_req, unf}, 3'b100);
    end

    // after a special case, a normal op clears flags
    launch(-9, 2, 1'b0);
    wait_done();
    chk("R5 flags cleared", {30'd0, ovf, halt_req}, 0);
    chk("R1 -9/2", result, -4);

    // done pulse width and hold
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done}, 0);
    held = result;
    repeat (5) @(negedge clk);
    chk("R9 result held", result, held);
    chk("R9 flags held", {30'd0, ovf, halt_req}, 0);

    // start while busy is ignored
    launch(100, 7, 1'b0);
    repeat (4) @(negedge clk);
    dividend = 32'h80000000;
    divisor  = 0;
    rem_sel  = 1'b1;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R10 latency unchanged", lat + 5, LAT);
    chk("R10 result from first op", result, 14);
    chk("R10 no halt", {31'd0, halt_req}, 0);
    @(negedge clk);
    chk("R10 no second done", {30'd0, done, busy}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule